// File: doc/BRIEF.md
# Double-Buffered DAC Load Controller

This block holds the digital side of a four-channel voltage-output converter. Every channel has two stages of storage. An input register receives codes from a serial front end, and a DAC register drives the converter. Write events arrive as one-cycle strobes that carry a channel mask, a code and two control flags: power-down and clear. A single write can target any subset of channels.

Codes reach the DAC registers only through an asynchronous active-low load strobe. The strobe is synchronised into the system clock. While it is low, each channel whose input register changed since its last transfer copies that input register into its DAC register. A channel whose input did not change is left alone, and its update strobe stays quiet, so the converter is not disturbed. A clear write empties the whole bank.

Each channel's power-down output combines an external power-down pin with a stored per-channel bit. Power-down never alters the stored codes.

Top module: `dac_load_ctrl`

## Requirements
- R1: A write (`wr_valid`=1, `wr_clr`=0) stores `wr_code` in the input register and `wr_pd` in the stored power-down bit of every channel whose `wr_mask` bit is 1, and marks that channel changed. `dac_code` does not move until a transfer. Channels whose mask bit is 0 are unaffected.
- R2: `ldac_n` passes through a two-flop synchroniser. If `ldac_n` is low before clock edge k and stays low, then at edge k+2 each changed channel loads its input register into `dac_code`. For as long as `ldac_n` stays low, a transfer happens on every edge at which a channel is marked changed.
- R3: A channel whose input register has not been written since its last transfer is not reloaded, and its `dac_upd` stays 0 even while the load strobe is active.
- R4: `dac_upd[i]` is high for exactly the one cycle after the edge at which channel i's DAC register was loaded by a transfer.
- R5: Synchronous reset (`rst`=1) sets every `dac_code` to zero and every `pd_out` and `dac_upd` bit to 0. All changed marks and stored power-down bits are cleared. `dac_code` then stays zero until a write is followed by a transfer.
- R6: A clear write (`wr_valid`=1, `wr_clr`=1) sets every input register and `dac_code` to zero on the next edge and clears every changed mark. The mask, code and power-down flag of that write are ignored, and the stored power-down bits are kept. A clear wins over a transfer in the same cycle, and it produces no `dac_upd` pulse.
- R7: Suppose a write and a transfer hit a channel at the same edge. The DAC register then takes the previous input value, the channel stays marked changed, and the new code is transferred at the next edge at which the load strobe is active.
- R8: `pd_out[i]` is registered. After each edge it equals `pd_pin` sampled at that edge OR channel i's stored power-down bit as it was before that edge. A power-down bit written at edge k therefore shows at edge k+1.
- R9: While a channel is powered down, its input register, DAC register and changed mark keep working and hold their contents. `dac_code` is never forced by power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, used as power-on reset |
| wr_valid | input | 1 | One-cycle write event from the serial front end |
| wr_mask | input | NUM_CH | Channel select mask of the write |
| wr_code | input | CODE_W | Code of the write |
| wr_pd | input | 1 | Power-down flag of the write |
| wr_clr | input | 1 | Clear flag of the write |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| pd_pin | input | 1 | External power-down request, active high |
| dac_code | output | NUM_CH*CODE_W | DAC register contents, channel i at bits [i*CODE_W +: CODE_W] |
| dac_upd | output | NUM_CH | One-cycle pulse per channel after a transfer |
| pd_out | output | NUM_CH | Effective per-channel power-down |

## Verification
The assertions take for granted that `wr_valid`, `wr_mask`, `wr_code`, `wr_pd`, `wr_clr` and `pd_pin` are synchronous to `clk`, and that only `ldac_n` is asynchronous. They also assume that the write fields carry no unknown values while `wr_valid` is high. The stimulus honours this by changing every input just after the falling edge of the clock. `ldac_n` is toggled with low runs of varying length, and random writes, clears and power-down pin changes are mixed in. This covers same-edge write-and-transfer and clear-during-transfer cases without any input changing on a rising edge.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_CODE_W = 12;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic clr;
    logic pd;
  } wr_flags_t;
endpackage

// File: rtl/ldac_sync.sv
module ldac_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ldac_n,
  output logic load_act
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], ldac_n};
  end

  assign load_act = ~chain_q[STAGES-1];

  // R2: a freshly released strobe never produces a load right after reset
  a_r2_idle_after_reset: assert property (@(posedge clk) rst |=> !load_act);
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              clr,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              pd_in,
  input  logic              pd_pin,
  output logic [CODE_W-1:0] dac_q,
  output logic              upd_q,
  output logic              pd_q
);
  logic [CODE_W-1:0] in_q;
  logic              dirty_q;
  logic              pdbit_q;
  logic              xfer;

  assign xfer = load && dirty_q && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= '0;
      dac_q   <= '0;
      dirty_q <= 1'b0;
      upd_q   <= 1'b0;
    end else if (clr) begin
      in_q    <= '0;
      dac_q   <= '0;
      dirty_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= xfer;
      if (xfer) dac_q <= in_q;
      if (wr_hit) in_q <= code_in;
      dirty_q <= wr_hit || (dirty_q && !load);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pdbit_q <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      if (wr_hit) pdbit_q <= pd_in;
      pd_q <= pd_pin | pdbit_q;
    end
  end

  // R2: a transfer copies the input register held before the edge
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    upd_q |-> dac_q == $past(in_q));
  // R3: an unchanged channel keeps its DAC register
  a_r3_no_reload_clean: assert property (@(posedge clk) disable iff (rst)
    (!dirty_q && !clr) |=> ($stable(dac_q) && !upd_q));
  // R7: a write colliding with a transfer keeps the channel marked
  a_r7_dirty_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && load && !clr) |=> dirty_q);
  // R8: the pin alone forces power-down on the next cycle
  a_r8_pin_forces_pd: assert property (@(posedge clk) disable iff (rst)
    pd_pin |=> pd_q);
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [NUM_CH-1:0]        wr_mask,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic                     wr_pd,
  input  logic                     wr_clr,
  input  logic                     ldac_n,
  input  logic                     pd_pin,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0]        dac_upd,
  output logic [NUM_CH-1:0]        pd_out
);
  localparam int unsigned BUS_W = NUM_CH * CODE_W;

  wr_flags_t flags;
  logic      load_act;
  logic      clr_evt;

  assign flags.clr = wr_clr;
  assign flags.pd  = wr_pd;
  assign clr_evt   = wr_valid && flags.clr;

  ldac_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .ldac_n   (ldac_n),
    .load_act (load_act)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_valid && !flags.clr && wr_mask[g];

    dac_channel #(.CODE_W(CODE_W)) i_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (hit),
      .clr     (clr_evt),
      .load    (load_act),
      .code_in (wr_code),
      .pd_in   (flags.pd),
      .pd_pin  (pd_pin),
      .dac_q   (dac_code[g*CODE_W +: CODE_W]),
      .upd_q   (dac_upd[g]),
      .pd_q    (pd_out[g])
    );
  end

  // R5: reset empties the bank
  a_r5_reset_zero: assert property (@(posedge clk)
    rst |=> (dac_code == {BUS_W{1'b0}} && dac_upd == '0 && pd_out == '0));
  // R6: clear empties every DAC register with no update pulse
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (dac_code == {BUS_W{1'b0}} && dac_upd == '0));
  // R4: update pulses only while the synchronised strobe was active
  a_r4_upd_needs_load: assert property (@(posedge clk) disable iff (rst)
    (dac_upd != '0) |-> $past(load_act));
endmodule

// File: tb/test_dac_load_ctrl.sv
`timescale 1ns/1ps
module test_dac_load_ctrl;
  localparam int NCH = 4;
  localparam int CW  = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_valid;
  logic [NCH-1:0] wr_mask;
  logic [CW-1:0] wr_code;
  logic          wr_pd;
  logic          wr_clr;
  logic          ldac_n;
  logic          pd_pin;
  logic [NCH*CW-1:0] dac_code;
  logic [NCH-1:0] dac_upd;
  logic [NCH-1:0] pd_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [CW-1:0] m_in  [NCH];
  logic [CW-1:0] m_dac [NCH];
  logic          m_dirty [NCH];
  logic          m_pdb [NCH];
  logic [NCH-1:0] m_upd, m_pdo;
  logic          m_s1, m_s2;

  dac_load_ctrl #(.NUM_CH(NCH), .CODE_W(CW)) i_dac_load_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_mask(wr_mask),
    .wr_code(wr_code), .wr_pd(wr_pd), .wr_clr(wr_clr), .ldac_n(ldac_n),
    .pd_pin(pd_pin), .dac_code(dac_code), .dac_upd(dac_upd), .pd_out(pd_out)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_in[i] = '0; m_dac[i] = '0; m_dirty[i] = 1'b0; m_pdb[i] = 1'b0;
    end
    m_upd = '0; m_pdo = '0; m_s1 = 1'b1; m_s2 = 1'b1;
  endtask

  // one clock edge of the requirement model, using the inputs now driven
  task automatic model_edge();
    logic ld, clr, hit;
    ld  = !m_s2;
    clr = wr_valid && wr_clr;
    for (int i = 0; i < NCH; i++) begin
      hit = wr_valid && !wr_clr && wr_mask[i];
      m_pdo[i] = pd_pin | m_pdb[i];
      if (clr) begin
        m_in[i] = '0; m_dac[i] = '0; m_dirty[i] = 1'b0; m_upd[i] = 1'b0;
      end else begin
        m_upd[i] = ld && m_dirty[i];
        if (m_upd[i]) m_dac[i] = m_in[i];
        if (hit) begin
          m_in[i] = wr_code; m_pdb[i] = wr_pd;
        end
        m_dirty[i] = hit || (m_dirty[i] && !ld);
      end
    end
    m_s2 = m_s1;
    m_s1 = ldac_n;
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < NCH; i++) begin
      checks++;
      if (dac_code[i*CW +: CW] !== m_dac[i]) begin
        errors++;
        $display("FAIL %s ch%0d code: actual %h expected %h", tag, i,
                 dac_code[i*CW +: CW], m_dac[i]);
      end
    end
    checks++;
    if (dac_upd !== m_upd) begin
      errors++;
      $display("FAIL %s upd: actual %b expected %b", tag, dac_upd, m_upd);
    end
    checks++;
    if (pd_out !== m_pdo) begin
      errors++;
      $display("FAIL %s pd: actual %b expected %b", tag, pd_out, m_pdo);
    end
  endtask

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    wr_valid = 1'b0;
  endtask

  task automatic wr(logic [NCH-1:0] m, logic [CW-1:0] c, logic p, logic cl);
    wr_valid = 1'b1; wr_mask = m; wr_code = c; wr_pd = p; wr_clr = cl;
  endtask

  task automatic direct(string tag, logic [CW-1:0] exp0, logic exp_upd0);
    checks++;
    if (dac_code[CW-1:0] !== exp0 || dac_upd[0] !== exp_upd0) begin
      errors++;
      $display("FAIL %s ch0: actual %h/%b expected %h/%b", tag,
               dac_code[CW-1:0], dac_upd[0], exp0, exp_upd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_valid = 1'b0; wr_mask = '0; wr_code = '0; wr_pd = 1'b0;
    wr_clr = 1'b0; ldac_n = 1'b1; pd_pin = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R5");
    direct("R5", 12'h000, 1'b0);

    // R1: write only, no transfer
    wr(4'b0101, 12'hABC, 1'b0, 1'b0);
    step("R1");
    direct("R1", 12'h000, 1'b0);
    repeat (3) step("R1");

    // R2: strobe low, transfer at second edge after
    ldac_n = 1'b0;
    step("R2");
    step("R2");
    direct("R2", 12'h000, 1'b0);
    step("R2");
    direct("R2", 12'hABC, 1'b1);
    // R3 R4: strobe held low, nothing changed, no reload
    step("R4");
    direct("R4", 12'hABC, 1'b0);
    repeat (3) step("R3");

    // R7: write while strobe active, transferred next edge
    wr(4'b0001, 12'h123, 1'b0, 1'b0);
    step("R7");
    direct("R7", 12'hABC, 1'b0);
    step("R7");
    direct("R7", 12'h123, 1'b1);
    ldac_n = 1'b1;
    repeat (3) step("R7");

    // R7 collision: write A, then write B on the first active load edge
    wr(4'b0001, 12'h0AA, 1'b0, 1'b0);
    step("R7");
    ldac_n = 1'b0;
    step("R7");
    step("R7");
    wr(4'b0001, 12'h0BB, 1'b0, 1'b0);
    step("R7");
    direct("R7", 12'h0AA, 1'b1);
    step("R7");
    direct("R7", 12'h0BB, 1'b1);

    // R6: clear beats a pending transfer
    wr(4'b0011, 12'hFFF, 1'b1, 1'b0);
    step("R6");
    wr(4'b0000, 12'h555, 1'b0, 1'b1);
    step("R6");
    direct("R6", 12'h000, 1'b0);
    repeat (3) step("R6");
    ldac_n = 1'b1;
    repeat (3) step("R6");

    // R8 R9: pin and stored bit, contents held
    pd_pin = 1'b1;
    step("R8");
    pd_pin = 1'b0;
    step("R8");
    wr(4'b1000, 12'h777, 1'b1, 1'b0);
    step("R8");
    step("R8");
    ldac_n = 1'b0;
    repeat (4) step("R9");
    ldac_n = 1'b1;
    repeat (3) step("R9");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) wr(4'($urandom), 12'($urandom), 1'($urandom), 1'b0);
      else if (r < 33) wr(4'($urandom), 12'($urandom), 1'($urandom), 1'b1);
      if ($urandom_range(0, 9) == 0) ldac_n = ~ldac_n;
      if ($urandom_range(0, 19) == 0) pd_pin = ~pd_pin;
      step("R2");
    end

    // R5: reset mid-run
    rst = 1'b1;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ldac_n = 1'b1; pd_pin = 1'b0;
    compare("R5");
    repeat (3) step("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule